// File: doc/BRIEF.md
# Multi-lane DDR serial deserializer with per-lane word slip

This block turns a group of source-synchronous serial lanes from a fast converter into parallel words. Each lane is sampled on both edges of a shared bit clock, so two bits enter per clock period. After every seven bits, one parallel word per lane is published together with a single-cycle strobe. The lane set is the converter's data lines plus one frame lane. The frame lane carries a fixed alternating pattern of seven ones and seven zeros, and is handled exactly like a data lane.

Word alignment is adjusted one lane at a time. A rising edge on a lane's slip input moves that lane's word boundary by one bit. All lanes still share one strobe. A controller outside the block pulses the frame lane's slip until its word reads all ones or all zeros. It then adjusts the data lanes in the same way, each by its own amount.

Top module: `lane_deser_array`

## Requirements
- R1: A synchronous reset clears every captured bit, every word output and the strobe, and returns each lane's boundary offset to zero.
- R2: In each bit-clock period the bit sampled on the rising edge is older than the bit sampled on the following falling edge. The two enter a lane's word history together on the next rising edge.
- R3: `word_valid` is a one-cycle pulse. It appears on the 4th rising edge after reset release and then alternately 3 and 4 cycles apart (edges 4, 7, 11, 14, ...), once for every seven bits received.
- R4: Bits are numbered from 0 in arrival order after reset, where bits 0 and 1 are the zeros that enter on the first rising edge. With offset 0, the k-th word (k from 1) of a lane holds bits 7k-7 to 7k-1, the oldest in bit 6.
- R5: Each rising edge of a lane's slip request raises that lane's offset s by one, modulo 7. The lane's k-th word then holds bits 7k-7-s to 7k-1-s, so seven slips restore the original alignment.
- R6: A slip on one lane leaves the words of every other lane unchanged.
- R7: A slip request held high for many cycles produces exactly one slip. Another slip needs a return to low first.
- R8: The word published on the clock edge that registers a slip's rising edge, and every later word, uses the new offset. Earlier words are not affected. Every word consists of seven bits that were fully received, and bits from before reset count as zero.
- R9: Between strobes, every word output holds its value.
- R10: The frame lane is the highest-index lane. With the alternating seven-ones/seven-zeros pattern, it produces 7'h7F or 7'h00 words after exactly as many slips as its bit misalignment requires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; both edges sample the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | LANES | One serial input per lane; the highest index is the frame lane |
| slip_req | input | LANES | Per-lane slip request, acted on at its rising edge |
| words | output | LANES*WORD_W | Parallel words, lane i at bits [i*WORD_W +: WORD_W] |
| word_valid | output | 1 | One-cycle strobe marking new words |

## Verification
A corrupted bit-phase counter shows at the ports as a strobe that arrives too early, too late or twice in a row, and this is visible within four clock cycles. A wrong per-lane offset or a lost history bit shows at the next strobe as that lane's word being a rotated or shifted copy of the expected bits, while the other lanes stay correct. A slip detector that acts on level instead of edge keeps moving the boundary while the request is held, so the words change pattern at every following strobe.

// File: rtl/lane_deser_pkg.sv
`timescale 1ns/1ps
package lane_deser_pkg;
   // bits entering per bit-clock period (rising plus falling edge)
   localparam int BITS_PER_CLK = 2;

   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ddr_pair_capture.sv
`timescale 1ns/1ps
module ddr_pair_capture #(
   parameter int LANES = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LANES-1:0] sdi,
   output logic [LANES-1:0] rise_bit,
   output logic [LANES-1:0] fall_bit
);
   // older sample of the pair, taken on the rising edge
   always_ff @(posedge clk) begin
      if (rst) rise_bit <= '0;
      else     rise_bit <= sdi;
   end

   // newer sample of the pair, taken on the falling edge
   always_ff @(negedge clk) begin
      if (rst) fall_bit <= '0;
      else     fall_bit <= sdi;
   end
endmodule

// File: rtl/word_phase.sv
`timescale 1ns/1ps
module word_phase
   import lane_deser_pkg::*;
#(
   parameter int WORD_W = 7
) (
   input  logic clk,
   input  logic rst,
   output logic tick,
   output logic tail
);
   localparam int CW = cnt_width(WORD_W) + 1;

   logic [CW-1:0] fill_q;
   logic [CW-1:0] fill_sum;

   assign fill_sum = fill_q + CW'(BITS_PER_CLK);
   assign tick     = (fill_sum >= CW'(WORD_W));
   // one bit of the incoming pair already belongs to the next word
   assign tail     = tick && (fill_sum != CW'(WORD_W));

   always_ff @(posedge clk) begin
      if (rst)       fill_q <= '0;
      else if (tick) fill_q <= fill_sum - CW'(WORD_W);
      else           fill_q <= fill_sum;
   end
endmodule

// File: rtl/lane_slicer.sv
`timescale 1ns/1ps
module lane_slicer
   import lane_deser_pkg::*;
#(
   parameter int WORD_W = 7,
   parameter int OFF_W  = cnt_width(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise_bit,
   input  logic              fall_bit,
   input  logic              slip,
   input  logic              tick,
   input  logic              tail,
   output logic [WORD_W-1:0] word,
   output logic [OFF_W-1:0]  offset
);
   localparam int HIST_W = 2 * WORD_W;
   localparam int SH_W   = $clog2(HIST_W);

   logic              slip_q;
   logic              slip_rise;
   logic [OFF_W-1:0]  off_q;
   logic [OFF_W-1:0]  off_d;
   logic [HIST_W-3:0] hist_q;
   logic [HIST_W-1:0] hist_d;
   logic [SH_W-1:0]   sh;
   logic [WORD_W-1:0] window;

   assign slip_rise = slip & ~slip_q;
   assign off_d     = !slip_rise                     ? off_q :
                      (off_q == OFF_W'(WORD_W - 1)) ? '0    :
                                                      off_q + OFF_W'(1);
   // newest bit at index 0, older bits above it
   assign hist_d    = {hist_q, rise_bit, fall_bit};
   assign sh        = SH_W'(off_d) + SH_W'(tail);
   assign window    = WORD_W'(hist_d >> sh);
   assign offset    = off_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slip_q <= 1'b0;
         off_q  <= '0;
         hist_q <= '0;
         word   <= '0;
      end else begin
         slip_q <= slip;
         off_q  <= off_d;
         hist_q <= hist_d[HIST_W-3:0];
         if (tick) word <= window;
      end
   end
endmodule

// File: rtl/lane_deser_array.sv
`timescale 1ns/1ps
module lane_deser_array
   import lane_deser_pkg::*;
#(
   parameter int LANES  = 9,
   parameter int WORD_W = 7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [LANES-1:0]        sdi,
   input  logic [LANES-1:0]        slip_req,
   output logic [LANES*WORD_W-1:0] words,
   output logic                    word_valid
);
   localparam int OFF_W = cnt_width(WORD_W);

   initial begin
      assert (WORD_W >= 3) else $error("WORD_W must be at least 3");
      assert (LANES >= 1)  else $error("LANES must be at least 1");
   end

   logic [LANES-1:0]       rise_bit;
   logic [LANES-1:0]       fall_bit;
   logic                   tick;
   logic                   tail;
   logic [LANES*OFF_W-1:0] lane_off;

   ddr_pair_capture #(.LANES(LANES)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .sdi      (sdi),
      .rise_bit (rise_bit),
      .fall_bit (fall_bit)
   );

   word_phase #(.WORD_W(WORD_W)) u_phase (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .tail (tail)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_slicer #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_slice (
         .clk      (clk),
         .rst      (rst),
         .rise_bit (rise_bit[g]),
         .fall_bit (fall_bit[g]),
         .slip     (slip_req[g]),
         .tick     (tick),
         .tail     (tail),
         .word     (words[g*WORD_W +: WORD_W]),
         .offset   (lane_off[g*OFF_W +: OFF_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) word_valid <= 1'b0;
      else     word_valid <= tick;
   end
endmodule

// File: rtl/lane_deser_chk.sv
`timescale 1ns/1ps
module lane_deser_chk #(
   parameter int LANES  = 9,
   parameter int WORD_W = 7,
   parameter int OFF_W  = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic [LANES-1:0]        slip_req,
   input logic [LANES*WORD_W-1:0] words,
   input logic                    word_valid,
   input logic [LANES*OFF_W-1:0]  lane_off
);
   logic             armed;
   logic [2:0]       gap_q;
   logic [LANES-1:0] slip_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed  <= 1'b0;
         gap_q  <= '0;
         slip_q <= '0;
      end else begin
         armed  <= 1'b1;
         slip_q <= slip_req;
         if (word_valid)         gap_q <= '0;
         else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!word_valid && words == '0 && lane_off == '0));

   p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst || !armed)
      word_valid |=> !word_valid);

   p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst || !armed)
      word_valid |-> (gap_q >= 3'd2 && gap_q <= 3'd4));

   p_no_overdue_r3: assert property (@(posedge clk) disable iff (rst || !armed)
      gap_q <= 3'd4);

   p_word_hold_r9: assert property (@(posedge clk) disable iff (rst || !armed)
      !word_valid |-> $stable(words));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      p_slip_step_r5: assert property (@(posedge clk) disable iff (rst || !armed)
         (slip_req[i] && !slip_q[i]) |=>
            (lane_off[i*OFF_W +: OFF_W] ==
               (($past(lane_off[i*OFF_W +: OFF_W]) == OFF_W'(WORD_W - 1)) ? '0 :
                $past(lane_off[i*OFF_W +: OFF_W]) + OFF_W'(1))));

      // no rising edge on this lane (held high or low): offset stays put
      p_edge_only_r7: assert property (@(posedge clk) disable iff (rst || !armed)
         !(slip_req[i] && !slip_q[i]) |=> $stable(lane_off[i*OFF_W +: OFF_W]));
   end
endmodule

bind lane_deser_array lane_deser_chk #(
   .LANES  (LANES),
   .WORD_W (WORD_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .slip_req   (slip_req),
   .words      (words),
   .word_valid (word_valid),
   .lane_off   (lane_off)
);

// File: tb/sim_lane_deser_array.sv
`timescale 1ns/1ps
module sim_lane_deser_array;
   localparam int LANES = 9;
   localparam int W     = 7;
   localparam int NV    = 9;
   // {hold cycles, slip mask}
   localparam logic [LANES+7:0] VEC [NV] = '{
      {8'd3, 9'h001},
      {8'd2, 9'h000},
      {8'd1, 9'h014},
      {8'd1, 9'h000},
      {8'd1, 9'h010},
      {8'd6, 9'h000},
      {8'd2, 9'h1C2},
      {8'd9, 9'h000},
      {8'd1, 9'h020}
   };

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic [LANES-1:0]     sdi = '0;
   logic [LANES-1:0]     slip = '0;
   logic [LANES*W-1:0]   words;
   logic                 word_valid;

   int                   checks = 0;
   int                   fails = 0;
   int                   t = 0;
   int                   n_app = 0;
   int                   offs [LANES];
   logic [LANES-1:0]     prev_slip = '0;
   logic [W-1:0]         exp_w [LANES];
   logic [W-1:0]         frame_seen = '0;
   string                tag = "R1";
   int                   tries;
   bit                   aligned;

   always #5 clk = ~clk;

   lane_deser_array #(.LANES(LANES), .WORD_W(W)) u0 (
      .clk        (clk),
      .rst        (rst),
      .sdi        (sdi),
      .slip_req   (slip),
      .words      (words),
      .word_valid (word_valid)
   );

   function automatic logic src_bit(input int lane, input int j);
      if (lane == LANES - 1) return (((j + 5) / 7) % 2) == 0;
      return ((j * (lane + 5) + (j / 3) * (lane + 2) + lane * 3) % 7) < 3;
   endfunction

   // bit number idx in arrival order after reset (two leading zeros)
   function automatic logic rx_bit(input int lane, input int idx);
      if (idx < 2) return 1'b0;
      return src_bit(lane, idx - 2);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst  = 1'b1;
      sdi  = '0;
      slip = '0;
      repeat (3) @(posedge clk);
      #2.5;
      check("R1", "valid in reset", W'(word_valid), '0);
      for (int l = 0; l < LANES; l++)
         check("R1", $sformatf("lane %0d word in reset", l), words[l*W +: W], '0);
      rst = 1'b0;
      t = 0;
      n_app = 0;
      prev_slip = '0;
      for (int l = 0; l < LANES; l++) begin
         offs[l]  = 0;
         exp_w[l] = '0;
      end
   endtask

   task automatic run_cycle(input logic [LANES-1:0] slip_v);
      int  kb;
      int  ka;
      logic v_exp;
      @(negedge clk);
      #2.5;
      for (int l = 0; l < LANES; l++) sdi[l] = src_bit(l, 2 * t);
      slip = slip_v;
      @(posedge clk);
      kb = n_app / W;
      n_app += 2;
      ka = n_app / W;
      for (int l = 0; l < LANES; l++)
         if (slip_v[l] && !prev_slip[l]) offs[l] = (offs[l] + 1) % W;
      prev_slip = slip_v;
      v_exp = (ka > kb);
      if (v_exp)
         for (int l = 0; l < LANES; l++)
            for (int b = 0; b < W; b++)
               exp_w[l][b] = rx_bit(l, W * ka - 1 - offs[l] - b);
      #2.5;
      check("R3", "valid strobe", W'(word_valid), W'(v_exp));
      if (word_valid) frame_seen = words[(LANES-1)*W +: W];
      for (int l = 0; l < LANES; l++)
         check(v_exp ? tag : "R9", $sformatf("lane %0d word", l),
               words[l*W +: W], exp_w[l]);
      for (int l = 0; l < LANES; l++) sdi[l] = src_bit(l, 2 * t + 1);
      t++;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      tag = "R1";
      repeat (3) run_cycle('0);
      tag = "R2/R4";
      repeat (14) run_cycle('0);

      tag = "R5/R6/R8";
      for (int v = 0; v < NV; v++)
         repeat (int'(VEC[v][LANES+7:LANES])) run_cycle(VEC[v][LANES-1:0]);
      repeat (6) run_cycle('0);

      // held request: one slip only
      tag = "R7";
      repeat (12) run_cycle(9'h008);
      repeat (6) run_cycle('0);

      // seven slips on lane 2 wrap back to the starting alignment
      tag = "R5";
      for (int p = 0; p < 7; p++) begin
         run_cycle(9'h004);
         run_cycle('0);
      end
      repeat (8) run_cycle('0);

      // frame lane alignment search from a fresh reset
      do_reset();
      tag = "R10";
      tries = 0;
      aligned = 1'b0;
      for (int a = 0; a < 8 && !aligned; a++) begin
         repeat (4) run_cycle('0);
         if (frame_seen == 7'h7F || frame_seen == 7'h00) aligned = 1'b1;
         else begin
            run_cycle(9'h100);
            tries++;
         end
      end
      check("R10", "frame aligned", W'(aligned), W'(1));
      check("R10", "slips to align frame", W'(tries), W'(3));

      // slips then reset: offsets back to zero
      repeat (2) begin
         run_cycle(9'h0FF);
         run_cycle('0);
      end
      do_reset();
      tag = "R1";
      repeat (12) run_cycle('0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule